// File: doc/BRIEF.md
# Hybrid Sparse-Fanout Prefix Adder

This block is a purely combinational unsigned adder built as a parallel prefix network. It is parameterised by a power-of-two width, with 64 bits as the main target. Two operands go in and a sum of the same width comes out, together with a carry-out. There is no carry-in: the carry entering bit 0 is always zero.

The network has three stages. First, every bit position forms a generate term (AND of the operand bits) and a propagate term (XOR of the operand bits). Second, a tree of log2(WIDTH) levels builds group generates. The first level pairs each bit with its right-hand neighbour, so every position gets a two-bit group. From the second level on, the columns are split into blocks of 2^l. Every column in the upper half of a block joins with the single column just under that half, so the nodes of one group all share one lower source. Where the lower span already reaches bit 0, the node keeps only the generate output. Third, each sum bit is the XOR of its propagate term and the group generate of the bits below it.

The block is meant to sit in a datapath as a fast adder of logarithmic depth that uses fewer prefix nodes than a fully dense tree.

Top module: `hybrid_prefix_adder`

## Requirements
- R1: For any operands, {carry_out, sum} equals the (WIDTH+1)-bit unsigned sum op_a + op_b.
- R2: sum[0] equals op_a[0] XOR op_b[0], because the carry entering bit 0 is zero.
- R3: When one operand is all zeros, sum equals the other operand and carry_out is 0.
- R4: When op_a AND op_b is zero in every bit, no carry is created: sum equals op_a OR op_b and carry_out is 0.
- R5: An all-ones operand plus the value 1 gives sum all zeros and carry_out 1, so the carry travels through every column.
- R6: All ones plus all ones gives sum equal to all ones with bit 0 cleared, and carry_out 1.
- R7: carry_out is 1 exactly when the result wraps, that is when sum is less than op_a as an unsigned number.
- R8: The alternating patterns work: 0101... plus 1010... gives all ones with no carry, and 0101... plus 0101... gives 1010... with no carry.
- R9: The outputs depend only on the present operands. There is no clock and no state, and the same operands always give the same result.
- R10: The construction is correct at WIDTH 16, 32 and 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| sum | output | WIDTH | Low WIDTH bits of op_a + op_b |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
Whenever the operands change, the bound checker compares the full result with a behavioural sum. It also checks the low sum bit, the zero-operand identity, the no-generate case and the link between carry-out and wrap-around. Those checks can only see the operands that happen to be applied. The bench's scenarios therefore supply the cases that matter: the all-ones operand plus 1 that drives a carry through every level of the tree, the alternating patterns, and operands repeated to show there is no state. Three separate instances are used to show that the generate loops build a correct tree at 16, 32 and 64 bits.

// File: rtl/hybrid_prefix_adder.sv
module hybrid_prefix_adder #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out
);
  localparam int LEVELS = $clog2(WIDTH);

  logic [WIDTH-1:0] gen_t [LEVELS+1];
  logic [WIDTH-1:0] prp_t [LEVELS+1];

  assign gen_t[0] = op_a & op_b;
  assign prp_t[0] = op_a ^ op_b;

  for (genvar i = 0; i < WIDTH; i++) begin : g_lvl1
    if (i == 0) begin : g_pass
      assign gen_t[1][i] = gen_t[0][i];
      assign prp_t[1][i] = prp_t[0][i];
    end else if (i == 1) begin : g_gray
      assign gen_t[1][i] = gen_t[0][i] | (prp_t[0][i] & gen_t[0][i-1]);
      assign prp_t[1][i] = 1'b0;
    end else begin : g_black
      assign gen_t[1][i] = gen_t[0][i] | (prp_t[0][i] & gen_t[0][i-1]);
      assign prp_t[1][i] = prp_t[0][i] & prp_t[0][i-1];
    end
  end

  for (genvar l = 2; l <= LEVELS; l++) begin : g_lvl
    localparam int BLK  = 1 << l;
    localparam int HALF = 1 << (l - 1);
    for (genvar i = 0; i < WIDTH; i++) begin : g_col
      localparam int POS  = i % BLK;
      localparam int BASE = i - POS;
      localparam int SRC  = BASE + HALF - 1;
      if (POS < HALF) begin : g_pass
        assign gen_t[l][i] = gen_t[l-1][i];
        assign prp_t[l][i] = prp_t[l-1][i];
      end else if (BASE == 0) begin : g_gray
        assign gen_t[l][i] = gen_t[l-1][i] | (prp_t[l-1][i] & gen_t[l-1][SRC]);
        assign prp_t[l][i] = 1'b0;
      end else begin : g_black
        assign gen_t[l][i] = gen_t[l-1][i] | (prp_t[l-1][i] & gen_t[l-1][SRC]);
        assign prp_t[l][i] = prp_t[l-1][i] & prp_t[l-1][SRC];
      end
    end
  end

  assign sum       = prp_t[0] ^ {gen_t[LEVELS][WIDTH-2:0], 1'b0};
  assign carry_out = gen_t[LEVELS][WIDTH-1];
endmodule

// File: rtl/hybrid_prefix_adder_chk.sv
module hybrid_prefix_adder_chk #(
  parameter int WIDTH = 64
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [WIDTH-1:0] sum,
  input logic             carry_out
);
  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, op_a} + {1'b0, op_b};

  always_comb begin
    if (!$isunknown({op_a, op_b})) begin
      a_r1_full_sum: assert ({carry_out, sum} == ref_total);
      a_r2_low_bit: assert (sum[0] == (op_a[0] ^ op_b[0]));
      if (op_b == '0) begin
        a_r3_zero_operand: assert (sum == op_a && !carry_out);
      end
      if ((op_a & op_b) == '0) begin
        a_r4_no_generate: assert (sum == (op_a | op_b) && !carry_out);
      end
      a_r7_wrap_carry: assert (carry_out == (sum < op_a));
    end
  end
endmodule

bind hybrid_prefix_adder hybrid_prefix_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a(op_a),
  .op_b(op_b),
  .sum(sum),
  .carry_out(carry_out)
);

// File: tb/hybrid_prefix_adder_bench.sv
module hybrid_prefix_adder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic clk = 1'b0;
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [63:0] a64, b64, s64;
  logic [31:0] a32, b32, s32;
  logic [15:0] a16, b16, s16;
  logic c64, c32, c16;

  hybrid_prefix_adder #(.WIDTH(64)) u_hybrid_prefix_adder (
    .op_a(a64), .op_b(b64), .sum(s64), .carry_out(c64));
  hybrid_prefix_adder #(.WIDTH(32)) u_hybrid_prefix_adder_w32 (
    .op_a(a32), .op_b(b32), .sum(s32), .carry_out(c32));
  hybrid_prefix_adder #(.WIDTH(16)) u_hybrid_prefix_adder_w16 (
    .op_a(a16), .op_b(b16), .sum(s16), .carry_out(c16));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles >= WATCHDOG_CYCLES) begin
      checks = checks + 1;
      failures = failures + 1;
      $display("FAIL R9 watchdog expired: actual=%0d cycles expected<%0d", cycles, WATCHDOG_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic compare(input string req, input int w, input logic [64:0] act, input logic [64:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s width=%0d actual=%h expected=%h", req, w, act, exp);
    end
  endtask

  task automatic check_pair(input logic [63:0] a, input logic [63:0] b, input string req);
    logic [64:0] e64, e32, e16;
    #3;
    a64 = a; b64 = b;
    a32 = a[31:0]; b32 = b[31:0];
    a16 = a[15:0]; b16 = b[15:0];
    #1;
    e64 = {1'b0, a} + {1'b0, b};
    e32 = {32'b0, ({1'b0, a[31:0]} + {1'b0, b[31:0]})};
    e16 = {48'b0, ({1'b0, a[15:0]} + {1'b0, b[15:0]})};
    compare(req, 64, {c64, s64}, e64);
    compare(req, 32, {32'b0, c32, s32}, e32);
    compare(req, 16, {48'b0, c16, s16}, e16);
  endtask

  task automatic test_zero;
    check_pair(64'h0, 64'h0, "R3 zero plus zero");
    check_pair(64'h0123_4567_89ab_cdef, 64'h0, "R3 b zero");
    check_pair(64'h0, 64'hfedc_ba98_7654_3210, "R3 a zero");
  endtask

  task automatic test_ripple;
    check_pair({64{1'b1}}, 64'h1, "R5 ones plus one");
    check_pair(64'h1, {64{1'b1}}, "R5 one plus ones");
    check_pair({64{1'b1}}, {64{1'b1}}, "R6 ones plus ones");
    checks = checks + 1;
    if (s64 !== 64'hffff_ffff_ffff_fffe || c64 !== 1'b1) begin
      failures = failures + 1;
      $display("FAIL R6 actual=%b_%h expected=1_fffffffffffffffe", c64, s64);
    end
  endtask

  task automatic test_alternating;
    check_pair(64'h5555_5555_5555_5555, 64'haaaa_aaaa_aaaa_aaaa, "R8 5 plus a");
    check_pair(64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555, "R8 5 plus 5");
    check_pair(64'haaaa_aaaa_aaaa_aaaa, 64'haaaa_aaaa_aaaa_aaaa, "R8 a plus a");
    check_pair(64'h3333_3333_3333_3333, 64'hcccc_cccc_cccc_cccc, "R4 disjoint nibbles");
  endtask

  task automatic test_boundaries;
    check_pair(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R7 top bits wrap");
    check_pair(64'h0000_0000_8000_8000, 64'h0000_0000_8000_8000, "R10 mid width carries");
    check_pair(64'h7fff_ffff_ffff_ffff, 64'h1, "R7 carry to top no wrap");
    check_pair(64'h0000_ffff_0000_ffff, 64'h0000_0001_0000_0001, "R2 block boundaries");
  endtask

  task automatic test_stateless;
    logic [64:0] first;
    check_pair(64'hdead_beef_cafe_f00d, 64'h1357_9bdf_2468_ace0, "R9 first");
    first = {c64, s64};
    check_pair({64{1'b1}}, 64'h1, "R9 intervening");
    check_pair(64'hdead_beef_cafe_f00d, 64'h1357_9bdf_2468_ace0, "R9 repeat");
    compare("R9 repeat equals first", 64, {c64, s64}, first);
  endtask

  task automatic test_random;
    for (int n = 0; n < 10000; n++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      check_pair(ra, rb, "R1 random R10");
    end
  endtask

  initial begin
    a64 = '0; b64 = '0; a32 = '0; b32 = '0; a16 = '0; b16 = '0;
    #1;
    compare("R3 initial zero inputs", 64, {c64, s64}, 65'h0);
    test_zero();
    test_ripple();
    test_alternating();
    test_boundaries();
    test_stateless();
    test_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule